// File: doc/BRIEF.md
# Defect-Aware Multi-Bit ECC Lookup Controller

This block sits beside a cache array protected by single-error-correct, double-error-detect codes. For every subblock access it decides whether the subblock needs the stronger multi-bit code, and where that code's check bits come from. Subblocks found to hold defective cells during memory test are registered through a plain install port. They become "m-blocks", whose check bits live in a small fully associative check-bit store. Every other subblock stays on the ordinary path, and the block hands its data straight through.

Two small least-recently-used buffers sit in front of the check-bit store. A corrected-data buffer keeps already-decoded copies of recent m-blocks, so a read that hits it needs neither the slow multi-bit decoder nor the store search. A clean-address filter remembers recent subblocks that are known not to be m-blocks, so those accesses skip the store search. The multi-bit encoder/decoder is external and is reached through a request/response handshake. One request is in flight at a time.

Back-pressure rules. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the result has been taken. The result is held, unchanged, while `res_valid` is high and `res_ready` is low. A coder request holds its payload until `cod_req_ready`. A coder response is taken when `cod_rsp_valid` and `cod_rsp_ready` are both high. The coder may take any number of cycles. The decoder used with this block answers after a fixed 82 cycles.

Top module: `mecc_lookup_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `res_valid` and `cod_req_valid` are 0, and all three structures are empty, so any first access reports the plain path.
- R2: A read whose address is in the corrected-data buffer returns the buffered data with `res_path` = 2 and issues no coder request.
- R3: An access whose address is in the clean-address filter returns `req_data` with `res_path` = 0 and issues no coder request.
- R4: An access that misses every structure returns `req_data` with `res_path` = 1, issues no coder request, and adds the address to the filter.
- R5: A read of an m-block that is absent from the buffer sends a coder request with `cod_req_op` = 0 (decode), carrying `req_data` and the stored check bits. It returns the coder's corrected data with `res_path` = 3 and adds that data to the buffer.
- R6: A write to an m-block sends a coder request with `cod_req_op` = 1 (encode) carrying the write data. The returned check bits replace the stored ones, and the result carries the write data with `res_path` = 3.
- R7: A write to an m-block held in the buffer replaces the buffered data with the write data, so a later read returns the written value.
- R8: When the corrected-data buffer is full, a new entry replaces the least recently used one. Recency is updated by read hits and installs, not by writes.
- R9: When the clean-address filter is full, a new address replaces the least recently used one. Recency is updated by hits and installs.
- R10: A `mark_valid` pulse while `req_ready` is high registers `mark_addr` with `mark_chk` as an m-block and removes that address from the filter. If the address is already registered, its check bits are replaced. The pulse is ignored when the store is full or `req_ready` is low.
- R11: Only one request is outstanding. `res_valid` holds `res_data`/`res_path` stable until `res_ready`, and `cod_req_valid` holds its payload stable until `cod_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_valid | input | 1 | Register an m-block (honoured while idle) |
| mark_addr | input | ADDR_W | Subblock address to register |
| mark_chk | input | CHK_W | Initial multi-bit check bits |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Subblock address |
| req_data | input | DATA_W | Write data, or raw array data on a read |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_path | output | 2 | 0 filter, 1 plain miss, 2 buffer hit, 3 coded |
| res_data | output | DATA_W | Result data |
| cod_req_valid | output | 1 | Coder request valid |
| cod_req_ready | input | 1 | Coder takes the request |
| cod_req_op | output | 1 | 0 decode, 1 encode |
| cod_req_data | output | DATA_W | Data to decode or encode |
| cod_req_chk | output | CHK_W | Stored check bits for a decode |
| cod_rsp_valid | input | 1 | Coder response valid |
| cod_rsp_ready | output | 1 | Block waits for a response |
| cod_rsp_data | input | DATA_W | Corrected data |
| cod_rsp_chk | input | CHK_W | Freshly encoded check bits |

## Verification
The hardest situation to reach is the corrected-data buffer evicting its least recently used entry after an order of hits, installs and recency-neutral writes. Recency is invisible at the ports. It shows only when a read that should still hit comes back with path 3 after a full 82-cycle decode. The bench reaches it by registering more m-blocks than the buffer holds. It then sweeps reads over an address window several times, interleaves writes to buffered and unbuffered m-blocks, and predicts every path from its own recency lists. A further hard case is a register pulse that lands while a decode is pending. The bench fires it from a parallel thread during the decoder wait and then shows that the address still takes the plain path.

// File: rtl/mecc_pkg.sv
package mecc_pkg;
  typedef enum logic [1:0] {
    PATH_FILT  = 2'd0,
    PATH_PLAIN = 2'd1,
    PATH_PDB   = 2'd2,
    PATH_CODED = 2'd3
  } path_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_CREQ,
    ST_CWAIT,
    ST_RESP
  } state_e;

  localparam logic OP_DECODE = 1'b0;
  localparam logic OP_ENCODE = 1'b1;
endpackage

// File: rtl/mecc_lru.sv
module mecc_lru #(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      valid,
  input  logic              touch_en,
  input  logic [(N>1?$clog2(N):1)-1:0] touch_idx,
  output logic [(N>1?$clog2(N):1)-1:0] victim_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  logic found;
  always_comb begin
    victim_idx = '0;
    found      = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid[i] && !found) begin
        victim_idx = IW'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++)
        if (age_q[i] == IW'(N - 1)) victim_idx = IW'(i);
    end
  end

  // R8
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/mecc_cam.sv
module mecc_cam #(
  parameter int N       = 4,
  parameter int TAG_W   = 8,
  parameter int PAY_W   = 8,
  parameter bit USE_LRU = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TAG_W-1:0]     lk_tag,
  output logic                 lk_hit,
  output logic [(N>1?$clog2(N):1)-1:0] lk_idx,
  output logic [PAY_W-1:0]     lk_pay,
  input  logic                 wr_en,
  input  logic [(N>1?$clog2(N):1)-1:0] wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [PAY_W-1:0]     wr_pay,
  input  logic                 inv_en,
  input  logic [(N>1?$clog2(N):1)-1:0] inv_idx,
  input  logic                 touch_en,
  input  logic [(N>1?$clog2(N):1)-1:0] touch_idx,
  output logic [(N>1?$clog2(N):1)-1:0] slot_idx,
  output logic                 slot_free
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [PAY_W-1:0] pay_q [N];
  logic [N-1:0]     match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i] <= '0;
        pay_q[i] <= '0;
      end
    end else begin
      if (inv_en) vld_q[inv_idx] <= 1'b0;
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        tag_q[wr_idx] <= wr_tag;
        pay_q[wr_idx] <= wr_pay;
      end
    end
  end

  always_comb begin
    lk_idx = '0;
    lk_pay = '0;
    for (int i = 0; i < N; i++) begin
      match[i] = vld_q[i] && (tag_q[i] == lk_tag);
      if (match[i]) begin
        lk_idx = IW'(i);
        lk_pay = pay_q[i];
      end
    end
    lk_hit    = |match;
    slot_free = ~&vld_q;
  end

  generate
    if (USE_LRU) begin : g_lru
      mecc_lru #(.N(N)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (vld_q),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (slot_idx)
      );
    end else begin : g_first_free
      logic unused_touch;
      assign unused_touch = ^{touch_en, touch_idx};
      always_comb begin
        slot_idx = '0;
        for (int i = N - 1; i >= 0; i--)
          if (!vld_q[i]) slot_idx = IW'(i);
      end
    end
  endgenerate

  // R10
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/mecc_lookup_ctrl.sv
module mecc_lookup_ctrl
  import mecc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int CHK_W   = 8,
  parameter int STORE_N = 8,
  parameter int PDB_N   = 4,
  parameter int FLT_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_valid,
  input  logic [ADDR_W-1:0] mark_addr,
  input  logic [CHK_W-1:0]  mark_chk,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [1:0]        res_path,
  output logic [DATA_W-1:0] res_data,
  output logic              cod_req_valid,
  input  logic              cod_req_ready,
  output logic              cod_req_op,
  output logic [DATA_W-1:0] cod_req_data,
  output logic [CHK_W-1:0]  cod_req_chk,
  input  logic              cod_rsp_valid,
  output logic              cod_rsp_ready,
  input  logic [DATA_W-1:0] cod_rsp_data,
  input  logic [CHK_W-1:0]  cod_rsp_chk
);
  localparam int SIW = (STORE_N > 1) ? $clog2(STORE_N) : 1;
  localparam int PIW = (PDB_N > 1) ? $clog2(PDB_N) : 1;
  localparam int FIW = (FLT_N > 1) ? $clog2(FLT_N) : 1;

  state_e            state_q, state_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  path_e             path_q, path_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic [SIW-1:0]    sidx_q;
  logic [PIW-1:0]    pidx_q;
  logic              phit_q;
  logic              coder_used_q;

  logic [ADDR_W-1:0] lk_tag;

  // check-bit store
  logic              s_hit, s_free, s_wr;
  logic [SIW-1:0]    s_idx, s_slot, s_wr_idx;
  logic [CHK_W-1:0]  s_pay, s_wr_pay;
  logic [ADDR_W-1:0] s_wr_tag;
  // corrected-data buffer
  logic              p_hit, p_free, p_wr, p_touch;
  logic [PIW-1:0]    p_idx, p_slot, p_wr_idx, p_touch_idx;
  logic [DATA_W-1:0] p_pay, p_wr_pay;
  // clean-address filter
  logic              f_hit, f_free, f_wr, f_inv, f_touch;
  logic [FIW-1:0]    f_idx, f_slot, f_touch_idx;
  logic [0:0]        f_pay;

  logic unused_free;
  assign unused_free = ^{p_free, f_free, f_pay};

  assign lk_tag = (state_q == ST_IDLE) ? mark_addr : addr_q;

  mecc_cam #(.N(STORE_N), .TAG_W(ADDR_W), .PAY_W(CHK_W), .USE_LRU(1'b0)) u_store (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_hit(s_hit), .lk_idx(s_idx), .lk_pay(s_pay),
    .wr_en(s_wr), .wr_idx(s_wr_idx), .wr_tag(s_wr_tag), .wr_pay(s_wr_pay),
    .inv_en(1'b0), .inv_idx('0), .touch_en(1'b0), .touch_idx('0),
    .slot_idx(s_slot), .slot_free(s_free)
  );

  mecc_cam #(.N(PDB_N), .TAG_W(ADDR_W), .PAY_W(DATA_W), .USE_LRU(1'b1)) u_pdb (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_hit(p_hit), .lk_idx(p_idx), .lk_pay(p_pay),
    .wr_en(p_wr), .wr_idx(p_wr_idx), .wr_tag(addr_q), .wr_pay(p_wr_pay),
    .inv_en(1'b0), .inv_idx('0), .touch_en(p_touch), .touch_idx(p_touch_idx),
    .slot_idx(p_slot), .slot_free(p_free)
  );

  mecc_cam #(.N(FLT_N), .TAG_W(ADDR_W), .PAY_W(1), .USE_LRU(1'b1)) u_flt (
    .clk(clk), .rst_n(rst_n), .lk_tag(lk_tag), .lk_hit(f_hit), .lk_idx(f_idx), .lk_pay(f_pay),
    .wr_en(f_wr), .wr_idx(f_slot), .wr_tag(addr_q), .wr_pay(1'b1),
    .inv_en(f_inv), .inv_idx(f_idx), .touch_en(f_touch), .touch_idx(f_touch_idx),
    .slot_idx(f_slot), .slot_free(f_free)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign res_valid     = (state_q == ST_RESP);
  assign cod_req_valid = (state_q == ST_CREQ);
  assign cod_rsp_ready = (state_q == ST_CWAIT);
  assign cod_req_op    = wr_q ? OP_ENCODE : OP_DECODE;
  assign cod_req_data  = data_q;
  assign cod_req_chk   = s_pay;
  assign res_path      = path_q;
  assign res_data      = out_q;

  always_comb begin
    state_d     = state_q;
    path_d      = path_q;
    out_d       = out_q;
    s_wr        = 1'b0;
    s_wr_idx    = s_slot;
    s_wr_tag    = addr_q;
    s_wr_pay    = cod_rsp_chk;
    p_wr        = 1'b0;
    p_wr_idx    = p_slot;
    p_wr_pay    = cod_rsp_data;
    p_touch     = 1'b0;
    p_touch_idx = p_idx;
    f_wr        = 1'b0;
    f_inv       = 1'b0;
    f_touch     = 1'b0;
    f_touch_idx = f_idx;
    unique case (state_q)
      ST_IDLE: begin
        if (mark_valid) begin
          s_wr_tag = mark_addr;
          s_wr_pay = mark_chk;
          if (s_hit) begin
            s_wr     = 1'b1;
            s_wr_idx = s_idx;
          end else if (s_free) begin
            s_wr = 1'b1;
          end
          if (s_hit || s_free) f_inv = f_hit;
        end
        if (req_valid) state_d = ST_SEARCH;
      end
      ST_SEARCH: begin
        if (!wr_q && p_hit) begin
          p_touch = 1'b1;
          path_d  = PATH_PDB;
          out_d   = p_pay;
          state_d = ST_RESP;
        end else if (f_hit) begin
          f_touch = 1'b1;
          path_d  = PATH_FILT;
          out_d   = data_q;
          state_d = ST_RESP;
        end else if (s_hit) begin
          state_d = ST_CREQ;
        end else begin
          f_wr        = 1'b1;
          f_touch     = 1'b1;
          f_touch_idx = f_slot;
          path_d      = PATH_PLAIN;
          out_d       = data_q;
          state_d     = ST_RESP;
        end
      end
      ST_CREQ: begin
        if (cod_req_ready) state_d = ST_CWAIT;
      end
      ST_CWAIT: begin
        if (cod_rsp_valid) begin
          path_d  = PATH_CODED;
          state_d = ST_RESP;
          if (wr_q) begin
            s_wr     = 1'b1;
            s_wr_idx = sidx_q;
            p_wr     = phit_q;
            p_wr_idx = pidx_q;
            p_wr_pay = data_q;
            out_d    = data_q;
          end else begin
            p_wr        = 1'b1;
            p_touch     = 1'b1;
            p_touch_idx = p_slot;
            out_d       = cod_rsp_data;
          end
        end
      end
      ST_RESP: begin
        if (res_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      wr_q         <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      path_q       <= PATH_PLAIN;
      out_q        <= '0;
      sidx_q       <= '0;
      pidx_q       <= '0;
      phit_q       <= 1'b0;
      coder_used_q <= 1'b0;
    end else begin
      state_q <= state_d;
      path_q  <= path_d;
      out_q   <= out_d;
      if (state_q == ST_IDLE && req_valid) begin
        wr_q         <= req_write;
        addr_q       <= req_addr;
        data_q       <= req_data;
        coder_used_q <= 1'b0;
      end
      if (state_q == ST_SEARCH) begin
        sidx_q <= s_idx;
        pidx_q <= p_idx;
        phit_q <= p_hit;
      end
      if (cod_req_valid && cod_req_ready) coder_used_q <= 1'b1;
    end
  end

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_path));
  // R11
  cod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cod_req_valid && !cod_req_ready |=> cod_req_valid && $stable(cod_req_data)
      && $stable(cod_req_chk) && $stable(cod_req_op));
  // R11
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || cod_req_valid || cod_rsp_ready) |-> !req_ready);
  // R2
  fast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_path != PATH_CODED |-> !coder_used_q);
  // R5
  coded_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_path == PATH_CODED |-> coder_used_q);
endmodule

// File: tb/test_mecc_lookup_ctrl.sv
module test_mecc_lookup_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mark_valid = 1'b0;
  logic [7:0]  mark_addr = '0;
  logic [7:0]  mark_chk = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_path;
  logic [15:0] res_data;
  logic        cod_req_valid;
  logic        cod_req_ready = 1'b0;
  logic        cod_req_op;
  logic [15:0] cod_req_data;
  logic [7:0]  cod_req_chk;
  logic        cod_rsp_valid = 1'b0;
  logic        cod_rsp_ready;
  logic [15:0] cod_rsp_data = '0;
  logic [7:0]  cod_rsp_chk = '0;

  always #5 clk = ~clk;

  mecc_lookup_ctrl i_mecc_lookup_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mark_valid(mark_valid), .mark_addr(mark_addr), .mark_chk(mark_chk),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_path(res_path), .res_data(res_data),
    .cod_req_valid(cod_req_valid), .cod_req_ready(cod_req_ready), .cod_req_op(cod_req_op),
    .cod_req_data(cod_req_data), .cod_req_chk(cod_req_chk),
    .cod_rsp_valid(cod_rsp_valid), .cod_rsp_ready(cod_rsp_ready),
    .cod_rsp_data(cod_rsp_data), .cod_rsp_chk(cod_rsp_chk)
  );

  int vectors = 0;
  int errors  = 0;

  function automatic logic [7:0] enc(input logic [15:0] d);
    return d[7:0] ^ d[15:8];
  endfunction
  function automatic logic [15:0] dec(input logic [15:0] d, input logic [7:0] c);
    return d ^ {2{c ^ enc(d)}};
  endfunction

  // reference state
  logic [15:0] mem [256];
  bit          is_m [256];
  logic [7:0]  mchk [256];
  int          mcount = 0;
  logic [7:0]  pq_addr [4];
  logic [15:0] pq_data [4];
  int          pn = 0;
  logic [7:0]  fq [4];
  int          fn = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pdb_find(input logic [7:0] a);
    for (int i = 0; i < pn; i++) if (pq_addr[i] == a) return i;
    return -1;
  endfunction
  function automatic int flt_find(input logic [7:0] a);
    for (int i = 0; i < fn; i++) if (fq[i] == a) return i;
    return -1;
  endfunction
  task automatic pdb_front(input int k);
    logic [7:0] a; logic [15:0] d;
    a = pq_addr[k]; d = pq_data[k];
    for (int i = k; i > 0; i--) begin pq_addr[i] = pq_addr[i-1]; pq_data[i] = pq_data[i-1]; end
    pq_addr[0] = a; pq_data[0] = d;
  endtask
  task automatic pdb_insert(input logic [7:0] a, input logic [15:0] d);
    if (pn < 4) pn++;
    for (int i = pn - 1; i > 0; i--) begin pq_addr[i] = pq_addr[i-1]; pq_data[i] = pq_data[i-1]; end
    pq_addr[0] = a; pq_data[0] = d;
  endtask
  task automatic flt_front(input int k);
    logic [7:0] a;
    a = fq[k];
    for (int i = k; i > 0; i--) fq[i] = fq[i-1];
    fq[0] = a;
  endtask
  task automatic flt_insert(input logic [7:0] a);
    if (fn < 4) fn++;
    for (int i = fn - 1; i > 0; i--) fq[i] = fq[i-1];
    fq[0] = a;
  endtask
  task automatic flt_remove(input int k);
    for (int i = k; i < fn - 1; i++) fq[i] = fq[i+1];
    fn--;
  endtask

  // coder model: decode after 82 cycles, encode after 2
  initial begin
    logic        op;
    logic [15:0] d;
    logic [7:0]  c;
    forever begin
      @(negedge clk);
      if (cod_req_valid) begin
        repeat (2) @(negedge clk);
        cod_req_ready = 1'b1;
        op = cod_req_op; d = cod_req_data; c = cod_req_chk;
        @(negedge clk);
        cod_req_ready = 1'b0;
        repeat (op ? 1 : 81) @(negedge clk);
        cod_rsp_data  = dec(d, c);
        cod_rsp_chk   = enc(d);
        cod_rsp_valid = 1'b1;
        while (!cod_rsp_ready) @(negedge clk);
        @(negedge clk);
        cod_rsp_valid = 1'b0;
      end
    end
  end

  task automatic install(input logic [7:0] a, input logic [7:0] c);
    int fi;
    if (is_m[a]) mchk[a] = c;
    else if (mcount < 8) begin
      is_m[a] = 1'b1; mchk[a] = c; mcount++;
      fi = flt_find(a);
      if (fi >= 0) flt_remove(fi);
    end
    @(negedge clk);
    mark_valid = 1'b1; mark_addr = a; mark_chk = c;
    @(negedge clk);
    mark_valid = 1'b0;
  endtask

  task automatic access(input bit w, input logic [7:0] a, input logic [15:0] wd, input string tag);
    logic [15:0] exp_d, dreq;
    logic [1:0]  exp_p;
    int          pi, fi;
    string       rt;
    dreq = w ? wd : mem[a];
    pi = pdb_find(a);
    fi = flt_find(a);
    if (!w && pi >= 0) begin
      exp_p = 2; exp_d = pq_data[pi]; pdb_front(pi); rt = "R2";
    end else if (fi >= 0) begin
      exp_p = 0; exp_d = dreq; flt_front(fi); rt = "R3";
    end else if (is_m[a]) begin
      exp_p = 3;
      if (w) begin
        exp_d = wd; mchk[a] = enc(wd); rt = "R6";
        if (pi >= 0) pq_data[pi] = wd;
      end else begin
        exp_d = dec(mem[a], mchk[a]); pdb_insert(a, exp_d); rt = "R5";
      end
    end else begin
      exp_p = 1; exp_d = dreq; flt_insert(a); rt = "R4";
    end
    if (w) mem[a] = wd;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_data = dreq;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    for (int k = 0; k < vectors % 3; k++) begin
      @(negedge clk);
      check(res_valid && !req_ready, "R11", "result held under back-pressure",
            {30'd0, res_valid, req_ready}, 32'h2);
    end
    check(res_path == exp_p, {rt, "/", tag}, $sformatf("path addr %0d", a), res_path, exp_p);
    check(res_data == exp_d, {rt, "/", tag}, $sformatf("data addr %0d", a), res_data, exp_d);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a]  = {a[7:0], ~a[7:0]} ^ (16'h0001 << (a % 16));
      is_m[a] = 1'b0;
      mchk[a] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    check(cod_req_valid == 1'b0, "R1", "cod_req_valid after reset", cod_req_valid, 0);

    // R1/R4/R9: empty structures, filter fills and evicts
    for (int a = 0; a < 8; a++) access(1'b0, 8'(a), '0, "R1");
    for (int a = 4; a < 8; a++) access(1'b0, 8'(a), '0, "R3");
    access(1'b0, 8'd5, '0, "R9");
    access(1'b0, 8'd0, '0, "R9");
    access(1'b0, 8'd4, '0, "R9");
    access(1'b0, 8'd6, '0, "R9");
    access(1'b1, 8'd7, 16'hbeef, "R9");
    access(1'b0, 8'd7, '0, "R3");

    // R10: register m-blocks, one currently in the filter
    install(8'd5, enc({8'd5, ~8'd5}));
    for (int a = 20; a < 26; a++) install(8'(a), enc({8'(a), ~8'(a)}));
    access(1'b0, 8'd5, '0, "R10");

    // R5/R8: corrected-data buffer fill, hits and eviction
    for (int r = 0; r < 3; r++)
      for (int a = 20; a < 26; a++) access(1'b0, 8'(a), '0, "R8");
    access(1'b0, 8'd24, '0, "R8");
    access(1'b0, 8'd22, '0, "R8");
    access(1'b0, 8'd5, '0, "R8");
    access(1'b0, 8'd24, '0, "R8");

    // R7/R6: writes to buffered and unbuffered m-blocks
    access(1'b1, 8'd24, 16'h1357, "R7");
    access(1'b0, 8'd24, '0, "R7");
    access(1'b1, 8'd21, 16'h2468, "R6");
    access(1'b0, 8'd21, '0, "R6");
    access(1'b1, 8'd20, 16'hcafe, "R8");
    access(1'b0, 8'd23, '0, "R8");
    access(1'b0, 8'd20, '0, "R8");

    // R10: full store ignores installs, re-install replaces check bits
    install(8'd26, 8'h5a);
    install(8'd27, 8'h11);
    access(1'b0, 8'd27, '0, "R10");
    access(1'b0, 8'd26, '0, "R10");
    install(8'd25, 8'h3c);
    for (int a = 20; a < 24; a++) access(1'b0, 8'(a), '0, "R10");
    access(1'b0, 8'd25, '0, "R10");

    // R10: install while busy is ignored
    for (int a = 20; a < 24; a++) access(1'b0, 8'(a), '0, "R8");
    fork
      access(1'b0, 8'd5, '0, "R10");
      begin
        repeat (30) @(negedge clk);
        mark_valid = 1'b1; mark_addr = 8'd40; mark_chk = 8'h77;
        @(negedge clk);
        mark_valid = 1'b0;
      end
    join
    access(1'b0, 8'd40, '0, "R10");

    // mixed sweep over a window
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < 32; a++)
        access((a % 7) == 3, 8'(a), 16'(a * 977 + r), "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule